// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog with two stages. An 8-bit control register selects one of four timeout lengths. A free-running interval counter counts toward the selected length. When the counter reaches it, the block sets an interrupt flag. If the reset stage is armed at that moment, a fixed grace countdown starts. When the countdown ends, the block drives a one-clock system reset pulse, unless software disarms the reset stage first.

Software services the watchdog by writing a kick bit, which restarts the interval count. The interval counter stops while both the reset arm bit and the external interrupt enable are low. A sticky flag records that the watchdog caused a reset. This flag survives the resets the watchdog itself triggers, so software can read it back afterwards. Two synchronous reset inputs are provided:
- `por` is the power-on reset and clears everything.
- `soft_rst` clears the run-time state but keeps the arm bit and the sticky flag.

Top module: `wdog_ctrl`

## Requirements
- R1: When `por` is active, all register bits clear. After that reset, `rd_data` reads 0x00, and `irq` and `sys_rst` are low.
- R2: The interrupt flag is register bit 3. It sets exactly 2^EXPn clocks after the interval count was cleared. n is the value of the select field in bits 5:4: 00 selects EXP0, 01 selects EXP1, 10 selects EXP2 and 11 selects EXP3.
- R3: Writing 1 to bit 0 (kick) clears the interval count. Bit 0 always reads 0.
- R4: When the arm bit (bit 1) is 0 and `irq_en` is 0, the interval counter holds its value and the flag never sets from a timeout.
- R5: While the counter is halted, writing the arm bit to 1 clears the interval count and starts the counter.
- R6: A write that changes the select field clears the interval count. During the grace countdown, such a write changes neither counter.
- R7: `irq` equals bit 3 AND `irq_en` AND `gie`.
- R8: If the arm bit is 1 when bit 3 becomes set, whether by a timeout or by a software write, `sys_rst` is high for exactly one clock, GRACE clocks after the flag was set.
- R9: Clearing the arm bit during the grace countdown cancels it, and no `sys_rst` pulse follows.
- R10: Bit 2 (the reset-cause flag) sets in the same cycle as the `sys_rst` pulse. `soft_rst` does not clear it; only `por` does. Software writes to bit 2 are ignored and never cause a reset.
- R11: `soft_rst` clears bits 5, 4 and 3, the interval count and the grace countdown, and keeps the arm bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Synchronous power-on reset, active high |
| soft_rst | input | 1 | Synchronous reset of other kinds, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| irq_en | input | 1 | Watchdog interrupt enable |
| gie | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| sys_rst | output | 1 | System reset pulse, one clock |

## Verification
The assertions assume that `por` is held high for at least one clock at time zero. They also assume that `soft_rst` follows `sys_rst` whenever it is fed back, so the pulse is always followed by a reset cycle.

The stimulus drives `por` before any other activity. It ties `soft_rst` to `sys_rst` through an OR with its own control. It changes the write strobe and data only on falling clock edges, and it holds each strobe for a single cycle. The bench shortens the interval exponents and the grace length so that every boundary is reached in a few hundred clocks.

// File: rtl/wdog_ctrl.sv
module wdog_ctrl #(
  parameter int EXP0  = 15,
  parameter int EXP1  = 18,
  parameter int EXP2  = 21,
  parameter int EXP3  = 24,
  parameter int GRACE = 512
) (
  input  logic       clk,
  input  logic       por,
  input  logic       soft_rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       irq_en,
  input  logic       gie,
  output logic       irq,
  output logic       sys_rst
);
  localparam int CW  = EXP3;
  localparam int CW1 = CW + 1;
  localparam int GW  = $clog2(GRACE);

  logic [1:0]    sel;
  logic          rst_en, rst_flag, int_flag, grace, fire_q;
  logic [CW-1:0] cnt;
  logic [GW-1:0] gcnt;
  logic [CW:0]   tgt;

  always_comb begin
    case (sel)
      2'd0:    tgt = (CW1'(1) << EXP0) - CW1'(1);
      2'd1:    tgt = (CW1'(1) << EXP1) - CW1'(1);
      2'd2:    tgt = (CW1'(1) << EXP2) - CW1'(1);
      default: tgt = (CW1'(1) << EXP3) - CW1'(1);
    endcase
  end

  wire run       = rst_en | irq_en;
  wire elapse    = run && ({1'b0, cnt} == tgt);
  wire sel_chg   = wr_en && (wr_data[5:4] != sel) && !grace;
  wire ewt_start = wr_en && wr_data[1] && !rst_en && !irq_en;
  wire cnt_clr   = (wr_en && wr_data[0]) || sel_chg || ewt_start;
  wire rst_en_nx = wr_en ? wr_data[1] : rst_en;
  wire sw_set    = wr_en && wr_data[3] && !int_flag;
  wire fire      = grace && (gcnt == GW'(GRACE - 1)) && rst_en;
  wire start     = (elapse || sw_set) && rst_en_nx && !grace;
  wire unused_wr = ^{wr_data[7:6], wr_data[2]};

  always_ff @(posedge clk) begin
    if (por) begin
      sel <= '0; rst_en <= 1'b0; rst_flag <= 1'b0; int_flag <= 1'b0;
      cnt <= '0; gcnt <= '0; grace <= 1'b0; fire_q <= 1'b0;
    end else if (soft_rst) begin
      sel <= '0; int_flag <= 1'b0;
      cnt <= '0; gcnt <= '0; grace <= 1'b0; fire_q <= 1'b0;
    end else begin
      if (wr_en) begin
        sel      <= wr_data[5:4];
        rst_en   <= wr_data[1];
        int_flag <= wr_data[3];
      end
      if (elapse) int_flag <= 1'b1;

      if (cnt_clr || elapse) cnt <= '0;
      else if (run)          cnt <= cnt + 1'b1;

      fire_q <= fire;
      if (start) begin
        grace <= 1'b1;
        gcnt  <= '0;
      end else if (grace) begin
        if (fire) begin
          grace    <= 1'b0;
          rst_flag <= 1'b1;
        end else if (!rst_en_nx) begin
          grace <= 1'b0;
        end else begin
          gcnt <= gcnt + 1'b1;
        end
      end
    end
  end

  assign rd_data = {2'b00, sel, int_flag, rst_flag, rst_en, 1'b0};
  assign irq     = int_flag & irq_en & gie;
  assign sys_rst = fire_q;

  assert_rst_pulse_R8: assert property (@(posedge clk) disable iff (por)
    sys_rst |=> !sys_rst);
  assert_grace_from_flag_R8: assert property (@(posedge clk) disable iff (por || soft_rst)
    $rose(grace) |-> int_flag);
  assert_rst_needs_arm_R9: assert property (@(posedge clk) disable iff (por)
    sys_rst |-> $past(rst_en));
  assert_cause_set_R10: assert property (@(posedge clk) disable iff (por)
    sys_rst |-> rst_flag);
  assert_cause_sticky_R10: assert property (@(posedge clk) disable iff (por)
    !$fell(rst_flag));
  assert_halt_hold_R4: assert property (@(posedge clk) disable iff (por || soft_rst)
    (!rst_en && !irq_en && !wr_en) |=> $stable(cnt));
endmodule

// File: tb/wdog_ctrl_bench.sv
module wdog_ctrl_bench;
  localparam int E0 = 4, E1 = 5, E2 = 6, E3 = 7, GR = 16;

  logic clk = 1'b0, por = 1'b1, tb_srst = 1'b0, wr_en = 1'b0, irq_en = 1'b0, gie = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic irq, sys_rst;
  wire  soft_rst = tb_srst | sys_rst;
  int checks = 0, failures = 0, pulses = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_ctrl #(.EXP0(E0), .EXP1(E1), .EXP2(E2), .EXP3(E3), .GRACE(GR)) u_wdog_ctrl (
    .clk(clk), .por(por), .soft_rst(soft_rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq_en(irq_en), .gie(gie), .irq(irq), .sys_rst(sys_rst));

  always @(negedge clk) if (sys_rst) pulses++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_por();
    por = 1'b1; irq_en = 1'b0; gie = 1'b0;
    tick(2);
    por = 1'b0;
  endtask

  task automatic t_reset();
    do_por();
    chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
    chk(irq == 1'b0 && sys_rst == 1'b0, "R1 outputs", {irq, sys_rst}, 0);
  endtask

  task automatic t_interval(input logic [1:0] s, input int e);
    do_por();
    irq_en = 1'b1;
    wr({2'b00, s, 4'b0001});
    chk(rd_data[0] == 1'b0, "R3 kick reads 0", rd_data[0], 0);
    tick((1 << e) - 1);
    chk(rd_data[3] == 1'b0, "R2 flag early", rd_data[3], 0);
    tick(1);
    chk(rd_data[3] == 1'b1, "R2 flag on time", rd_data[3], 1);
    chk(irq == 1'b0, "R7 irq gie=0", irq, 0);
    gie = 1'b1; #1;
    chk(irq == 1'b1, "R7 irq all set", irq, 1);
    irq_en = 1'b0; #1;
    chk(irq == 1'b0, "R7 irq irq_en=0", irq, 0);
    gie = 1'b0;
  endtask

  task automatic t_kick();
    do_por();
    irq_en = 1'b1;
    wr(8'h01);
    tick(10);
    wr(8'h01);
    tick(15);
    chk(rd_data[3] == 1'b0, "R3 kick restarts", rd_data[3], 0);
    tick(1);
    chk(rd_data[3] == 1'b1, "R3 flag after kick", rd_data[3], 1);
  endtask

  task automatic t_sel_change();
    do_por();
    irq_en = 1'b1;
    wr(8'h01);
    tick(10);
    wr(8'h10);
    tick(31);
    chk(rd_data[3] == 1'b0, "R6 sel change clears", rd_data[3], 0);
    tick(1);
    chk(rd_data[3] == 1'b1, "R6 flag new interval", rd_data[3], 1);
  endtask

  task automatic t_halt_and_abort();
    int p0;
    do_por();
    irq_en = 1'b1;
    wr(8'h01);
    tick(8);
    irq_en = 1'b0;
    tick(100);
    chk(rd_data[3] == 1'b0, "R4 halted no flag", rd_data[3], 0);
    wr(8'h02);
    tick(15);
    chk(rd_data[3] == 1'b0, "R5 arm clears count", rd_data[3], 0);
    tick(1);
    chk(rd_data[3] == 1'b1, "R5 flag after arm", rd_data[3], 1);
    p0 = pulses;
    tick(3);
    wr(8'h00);
    tick(3 * GR);
    chk(pulses == p0, "R9 abort no reset", pulses, p0);
  endtask

  task automatic t_grace();
    int p0;
    do_por();
    p0 = pulses;
    wr(8'h12);
    tick(40);
    wr(8'h3A);
    tick(6);
    chk(sys_rst == 1'b0, "R8 no early reset", sys_rst, 0);
    chk(rd_data[2] == 1'b0, "R10 cause not yet", rd_data[2], 0);
    tick(1);
    chk(sys_rst == 1'b1, "R8 reset on time", sys_rst, 1);
    chk(rd_data[2] == 1'b1, "R10 cause set", rd_data[2], 1);
    tick(1);
    chk(sys_rst == 1'b0, "R8 one-clock pulse", sys_rst, 0);
    chk(pulses == p0 + 1, "R8 pulse count", pulses, p0 + 1);
    chk(rd_data == 8'h06, "R11 soft reset state", rd_data, 8'h06);
    do_por();
    chk(rd_data[2] == 1'b0, "R10 por clears cause", rd_data[2], 0);
  endtask

  task automatic t_sw_set();
    int p0;
    do_por();
    wr(8'h04);
    chk(rd_data[2] == 1'b0, "R10 write ignored", rd_data[2], 0);
    p0 = pulses;
    tick(50);
    chk(pulses == p0, "R10 write no reset", pulses, p0);
    irq_en = 1'b0;
    wr(8'h02);
    wr(8'h0A);
    tick(15);
    chk(sys_rst == 1'b0, "R8 sw set early", sys_rst, 0);
    tick(1);
    chk(sys_rst == 1'b1, "R8 sw set reset", sys_rst, 1);
  endtask

  initial begin
    tick(1);
    t_reset();
    t_interval(2'd0, E0);
    t_interval(2'd2, E2);
    t_interval(2'd3, E3);
    t_kick();
    t_sel_change();
    t_halt_and_abort();
    t_grace();
    t_sw_set();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule